// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (256 x 8)

This block models the slave side of a two-wire serial EEPROM that holds 256 bytes. It watches sampled clock (SCL) and data (SDA) lines and finds start and stop conditions in them. Each transfer opens with a device-select byte, which is compared against a fixed mask. A write transfer carries an 8-bit word address and then any number of data bytes. A read transfer streams bytes out of the array. Whichever the direction, the held address steps by one after every byte and wraps modulo 256.

The held word address survives a repeated start. A master therefore performs a random read by writing the word address, issuing a repeated start and sending a read select. A read select that follows a fresh start, with no word address before it, reads from wherever the address was left. The SDA output is registered and uses released-is-1 signalling, so the integrator combines it with the bus as an open-drain pull. Both line inputs are expected to arrive already synchronised to `clk`. Each one is sampled once per clock cycle.

Top module: `tw_eeprom_slave`

## Requirements
- R1: While `rst` is high and after it falls, `sda_o` is 1 and the held word address is 0.
- R2: SDA falling between two samples while SCL was high in the earlier sample is a start condition. It releases `sda_o` on the next cycle and begins receiving a select byte. The held word address is not changed, so a read select that follows returns the byte at the address left by earlier transfers.
- R3: SDA rising between two samples while SCL was high in the earlier sample is a stop condition. It returns the block to idle and releases `sda_o`, and takes priority over SCL edge handling. A data byte cut short by a stop is not stored.
- R4: The select byte is sampled MSB first on 8 SCL rising edges. It is accepted when bit 7 and bit 5 are both 1 (mask 0xA0), whatever the other bits hold. Acceptance drives `sda_o` low from the ninth SCL rising edge until the falling edge that follows it. Bit 0 set to 1 selects a read and bit 0 set to 0 selects a write.
- R5: A select byte that fails the mask is not acknowledged. `sda_o` stays 1 through the ninth clock, and the block ignores the bus until the next start condition.
- R6: After a write select, the block receives an 8-bit word address MSB first and acknowledges it. Each following data byte (MSB first) is acknowledged and stored at the held address, and the held address then increments.
- R7: After a read select, the block returns the byte at the held address. Each bit appears on `sda_o` after an SCL rising edge, MSB first. The held address increments after every byte that is sent.
- R8: When the master holds SDA low at the ninth SCL rising edge of a read byte, the next byte comes from the incremented address. When the master leaves SDA high, no new byte is fetched.
- R9: A write select, a word address, a repeated start and a read select together return data starting at that word address.
- R10: The held address wraps from 0xFF to 0x00 for both writes and reads.
- R11: `sda_o` is low only during an acknowledge clock or while a read data bit of value 0 is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both lines are sampled once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line as driven by the master |
| sda_o | output | 1 | Registered slave data drive, 1 = released, 0 = pull low |

## Verification
The hardest situation to reach from the ports is a transfer whose address has run past 0xFF. A second hard case is a data byte that a stop condition cuts off halfway, where storage must stay untouched and the held address must not move. The stimulus first fills the whole array with one sequential write. It then streams 257 bytes back through master acknowledges, so the address crosses the end of the array. It also writes three bytes from 0xFE, and it aborts a byte after four bits and reads that location again. A sweep over all 256 select values checks the mask decision. A final reset followed by a current-address read confirms where the address restarts.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

  // protocol phases of the slave controller
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // waiting for a start condition
    ST_SEL   = 3'd1,  // shifting in the device-select byte
    ST_WADDR = 3'd2,  // shifting in the word address
    ST_RD    = 3'd3,  // presenting read data bits
    ST_WR    = 3'd4,  // shifting in write data bits
    ST_ACK   = 3'd5,  // slave acknowledge clock
    ST_NAK   = 3'd6,  // select rejected, line released
    ST_AWAIT = 3'd7   // waiting for the master's ack after a read byte
  } tw_state_e;

endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_q, sda_q;

  // previous-sample history of both lines
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b0;
      sda_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = ~scl_q & scl_i;
  assign scl_fall = scl_q & ~scl_i;
  assign start_ev = scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/tw_eeprom_store.sv
module tw_eeprom_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // one write port, one registered read port with enable
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/tw_eeprom_ctrl.sv
module tw_eeprom_ctrl
  import tw_eeprom_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter int unsigned SEL_MASK = 'hA0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_i,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          sda_o
);

  localparam int MAXB = (DW > AW) ? DW : AW;
  localparam int CW   = $clog2(MAXB + 1);
  localparam logic [DW-1:0] MASK_V = DW'(SEL_MASK);
  localparam logic [CW-1:0] DW_C   = CW'(DW);
  localparam logic [CW-1:0] AW_C   = CW'(AW);

  tw_state_e     state_q, next_q;
  logic [CW-1:0] bitcnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] sh_q;
  logic          rw_q;
  logic          sda_q;
  logic          rd_bit;
  logic          sel_ok;
  logic          edge_ok;

  assign edge_ok  = ~start_ev & ~stop_ev;
  assign sel_ok   = (sh_q & MASK_V) == MASK_V;
  assign mem_addr = addr_q;
  assign mem_wdata = sh_q;
  assign sda_o    = sda_q;

  // bit of the fetched byte selected by the counter, MSB first
  always_comb begin
    rd_bit = 1'b1;
    for (int i = 0; i < DW; i++) begin
      if (bitcnt_q == CW'(DW - 1 - i)) rd_bit = mem_rdata[i];
    end
  end

  // storage strobes aligned with the register updates below
  always_comb begin
    mem_we = 1'b0;
    mem_re = 1'b0;
    if (edge_ok) begin
      if (scl_fall && state_q == ST_WR && bitcnt_q >= DW_C) mem_we = 1'b1;
      if (scl_fall && state_q == ST_SEL && bitcnt_q >= DW_C && sel_ok && sh_q[0])
        mem_re = 1'b1;
      if (scl_rise && state_q == ST_AWAIT && !sda_i) mem_re = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      next_q   <= ST_IDLE;
      bitcnt_q <= '0;
      addr_q   <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      sda_q    <= 1'b1;
    end else if (start_ev) begin
      state_q  <= ST_SEL;
      bitcnt_q <= '0;
      sda_q    <= 1'b1;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      sda_q   <= 1'b1;
    end else if (scl_rise) begin
      case (state_q)
        ST_SEL, ST_WR: begin
          if (bitcnt_q < DW_C) sh_q <= {sh_q[DW-2:0], sda_i};
          bitcnt_q <= bitcnt_q + CW'(1);
        end
        ST_WADDR: begin
          if (bitcnt_q < AW_C) addr_q <= {addr_q[AW-2:0], sda_i};
          bitcnt_q <= bitcnt_q + CW'(1);
        end
        ST_RD: begin
          if (bitcnt_q < DW_C) sda_q <= rd_bit;
          bitcnt_q <= bitcnt_q + CW'(1);
        end
        ST_NAK:   sda_q <= 1'b1;
        ST_ACK:   sda_q <= 1'b0;
        ST_AWAIT: if (!sda_i) next_q <= ST_RD;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state_q)
        ST_SEL: begin
          if (bitcnt_q >= DW_C) begin
            sda_q <= 1'b1;
            if (sel_ok) begin
              state_q  <= ST_ACK;
              rw_q     <= sh_q[0];
              next_q   <= sh_q[0] ? ST_RD : ST_WADDR;
              bitcnt_q <= '0;
            end else begin
              state_q <= ST_NAK;
              next_q  <= ST_IDLE;
            end
          end
        end
        ST_WADDR: begin
          if (bitcnt_q >= AW_C) begin
            state_q  <= ST_ACK;
            sda_q    <= 1'b1;
            next_q   <= rw_q ? ST_IDLE : ST_WR;
            bitcnt_q <= '0;
          end
        end
        ST_RD: begin
          if (bitcnt_q >= DW_C) begin
            state_q <= ST_AWAIT;
            addr_q  <= addr_q + AW'(1);
          end
        end
        ST_WR: begin
          if (bitcnt_q >= DW_C) begin
            state_q  <= ST_ACK;
            next_q   <= ST_WR;
            addr_q   <= addr_q + AW'(1);
            bitcnt_q <= '0;
          end
        end
        ST_NAK: begin
          state_q  <= ST_IDLE;
          bitcnt_q <= '0;
          sda_q    <= 1'b1;
        end
        ST_ACK, ST_AWAIT: begin
          state_q  <= next_q;
          bitcnt_q <= '0;
          sda_q    <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave #(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter int unsigned SEL_MASK = 'hA0
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o
);

  logic          scl_rise, scl_fall, start_ev, stop_ev;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  tw_line_sampler u_smp (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  tw_eeprom_ctrl #(.AW(AW), .DW(DW), .SEL_MASK(SEL_MASK)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sda_o     (sda_o)
  );

  tw_eeprom_store #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_addr),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/tw_eeprom_checker.sv
module tw_eeprom_checker
  import tw_eeprom_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_i,
  input logic          sda_o,
  input tw_state_e     state,
  input logic [AW-1:0] addr,
  input logic [3:0]    bitcnt
);

  // set once a clock edge has passed with reset low
  logic armed_q;
  always_ff @(posedge clk) armed_q <= ~rst;

  // R2: a start condition opens select reception with the line released
  a_r2_start_opens_select: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(scl_i) && $past(sda_i) && !sda_i)
      |=> (state == ST_SEL && sda_o));

  // R3: a stop condition returns to idle with the line released
  a_r3_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(scl_i) && !$past(sda_i) && sda_i)
      |=> (state == ST_IDLE && sda_o));

  // R4: the bit counter never runs past one byte or address
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
    32'(bitcnt) <= ((DW > AW) ? DW : AW));

  // R5: a rejected select never pulls the line
  a_r5_nak_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NAK) |-> sda_o);

  // R6: the held address moves only while receiving or transferring bytes
  a_r6_addr_moves_in_transfer: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !$stable(addr))
      |-> ($past(state) == ST_WADDR || $past(state) == ST_WR || $past(state) == ST_RD));

  // R11: the line is low only for an acknowledge or a read data bit
  a_r11_low_only_ack_or_data: assert property (@(posedge clk) disable iff (rst)
    !sda_o |-> (state == ST_ACK || state == ST_RD || state == ST_AWAIT));

endmodule

bind tw_eeprom_slave tw_eeprom_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .scl_i  (scl_i),
  .sda_i  (sda_i),
  .sda_o  (sda_o),
  .state  (u_ctl.state_q),
  .addr   (u_ctl.addr_q),
  .bitcnt (u_ctl.bitcnt_q)
);

// File: tb/tw_eeprom_slave_test.sv
`timescale 1ns/1ps
module tw_eeprom_slave_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic sda_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] cur;

  always #10 clk = ~clk;

  tw_eeprom_slave uut (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl),
    .sda_i (sda),
    .sda_o (sda_o)
  );

  task automatic chk(input string tag, input int got, input int expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, expv);
    end
  endtask

  task automatic drive(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
    @(negedge clk);
  endtask

  task automatic do_start();
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
  endtask

  task automatic do_stop();
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
  endtask

  task automatic put_bit(input logic b);
    drive(1'b0, b);
    drive(1'b1, b);
    drive(1'b0, b);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    acked = (sda_o == 1'b0);
    drive(1'b0, 1'b1);
  endtask

  task automatic get_byte(input logic master_nak, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b1);
      v[i] = sda_o;
      drive(1'b0, 1'b1);
    end
    drive(1'b0, master_nak);
    drive(1'b1, master_nak);
    drive(1'b0, master_nak);
  endtask

  // write select + word address, repeated start, read select
  task automatic point_read(input logic [7:0] a);
    logic ak;
    do_start();
    put_byte(8'hA0, ak); chk("R4 write select ack", ak, 1);
    put_byte(a, ak);     chk("R6 word address ack", ak, 1);
    do_start();
    put_byte(8'hA1, ak); chk("R9 read select ack", ak, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] v;

    repeat (3) @(negedge clk);
    chk("R1 sda released in reset", sda_o, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 sda released after reset", sda_o, 1);

    // R6: fill the array with one sequential write from 0
    do_start();
    put_byte(8'hA0, ak); chk("R4 select ack", ak, 1);
    put_byte(8'h00, ak); chk("R6 address ack", ak, 1);
    for (int i = 0; i < 256; i++) begin
      exp_mem[i] = 8'((i * 37 + 5) & 255);
      put_byte(exp_mem[i], ak);
      chk("R6 data ack", ak, 1);
    end
    do_stop();
    chk("R3 released after stop", sda_o, 1);

    // R7 R8 R10: stream 257 bytes back across the wrap
    point_read(8'h00);
    for (int i = 0; i < 257; i++) begin
      get_byte(i == 256, v);
      chk("R7 R8 R10 sequential read", v, exp_mem[i % 256]);
    end
    do_stop();

    // R2: current-address read continues from 1 after the wrap
    do_start();
    put_byte(8'hA1, ak); chk("R4 read select ack", ak, 1);
    get_byte(1'b1, v);
    chk("R2 held address kept", v, exp_mem[1]);
    do_stop();

    // R9: random read from the middle
    point_read(8'h5C);
    get_byte(1'b0, v); chk("R9 random read", v, exp_mem[8'h5C]);
    get_byte(1'b1, v); chk("R8 next after master ack", v, exp_mem[8'h5D]);
    do_stop();

    // R10: write wraps from 0xFF to 0x00
    do_start();
    put_byte(8'hA0, ak); chk("R4 select ack", ak, 1);
    put_byte(8'hFE, ak); chk("R6 address ack", ak, 1);
    put_byte(8'h11, ak); chk("R6 data ack", ak, 1);
    put_byte(8'h22, ak); chk("R6 data ack", ak, 1);
    put_byte(8'h33, ak); chk("R10 data ack at wrap", ak, 1);
    do_stop();
    exp_mem[8'hFE] = 8'h11;
    exp_mem[8'hFF] = 8'h22;
    exp_mem[8'h00] = 8'h33;
    point_read(8'hFE);
    for (int i = 0; i < 3; i++) begin
      get_byte(i == 2, v);
      chk("R10 write wrap readback", v, exp_mem[(8'hFE + i) % 256]);
    end
    do_stop();

    // R3: stop cuts a data byte after four bits, nothing stored
    do_start();
    put_byte(8'hA0, ak); chk("R4 select ack", ak, 1);
    put_byte(8'h40, ak); chk("R6 address ack", ak, 1);
    for (int i = 0; i < 4; i++) put_bit(~exp_mem[8'h40][7 - i]);
    do_stop();
    chk("R3 released after abort", sda_o, 1);
    do_start();
    put_byte(8'hA1, ak); chk("R4 read select ack", ak, 1);
    get_byte(1'b1, v);
    chk("R3 aborted byte not stored", v, exp_mem[8'h40]);
    do_stop();

    // R4 R5: every select value against the 0xA0 mask
    for (int s = 0; s < 256; s++) begin
      do_start();
      put_byte(8'(s), ak);
      chk(((s & 8'hA0) == 8'hA0) ? "R4 select accepted" : "R5 select rejected",
          ak, ((s & 8'hA0) == 8'hA0) ? 1 : 0);
      if ((s & 8'hA0) != 8'hA0) begin
        // R5: further bytes are ignored until a new start
        put_byte(8'hA1, ak);
        chk("R5 ignored after reject", ak, 0);
      end
      do_stop();
    end

    // R1: reset sends the held address back to 0
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 sda released in reset", sda_o, 1);
    rst = 1'b0;
    do_start();
    put_byte(8'hA1, ak); chk("R4 read select ack", ak, 1);
    get_byte(1'b1, v);
    chk("R1 address zero after reset", v, exp_mem[0]);
    do_stop();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule